// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches three 8-bit general-purpose I/O ports and turns selected pin activity into interrupts. Each pin is set up by two configuration bits. One chooses level or edge detection. The other chooses the active polarity: low or falling when 0, high or rising when 1. Each pin also has an enable bit and an optional debounce qualifier. Pin inputs are resynchronised to the clock before any decision is made.

Software reaches all configuration through a byte-wide register bus. It reads a status byte per port and acknowledges latched edges by writing ones to that port's end-of-interrupt register. Ports 0 and 1 feed a single combined interrupt output. Port 2 drives one interrupt line per pin. Each port also holds an output data register and a direction register that drive the pads.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every configuration, enable, data, direction and status register reads 0, and `irq_shared`, `irq_line`, `pin_out` and `pin_oe` are all 0.
- R2: A pin whose mode bit is 0 (level) shows status 1 exactly while its qualified input equals its polarity bit (1 = high active, 0 = low active). The status follows the pin back to 0 when the level goes away.
- R3: A pin whose mode bit is 1 (edge) latches status 1 on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The latched status stays at 1 while the pin keeps changing, until it is acknowledged.
- R4: Writing the end-of-interrupt register clears the latched edge of each bit written as 1. Bits written as 0 leave their latch unchanged.
- R5: A pin whose enable bit is 0 reads status 0 and asserts no output. An edge that occurs while the pin is disabled is not recorded.
- R6: With a pin's debounce bit at 1, a new level is accepted only after the synchronised input has differed from the accepted level for DEB_CYCLES consecutive clocks (default 4). A shorter pulse is discarded. With the bit at 0, a single-clock pulse is accepted.
- R7: `irq_shared` is the OR of the status bytes of ports 0 and 1, registered one clock.
- R8: `irq_line[i]` is status bit i of port 2, registered one clock.
- R9: Writing the mode or polarity register does not clear a latched edge.
- R10: `pin_out` and `pin_oe` carry each port's data and direction registers (1 = driven). A data read returns the data register bit for driven pins and the synchronised pad level for the other pins.
- R11: Byte offsets for mode, polarity, end-of-interrupt, enable, debounce and status are as follows. Port 0 uses 0x90, 0x94, 0x98, 0x9C, 0xA8 and 0xA0. Port 1 uses 0xAC, 0xB0, 0xB4, 0xB8, 0xC4 and 0xBC. Port 2 uses 0x4C, 0x50, 0x54, 0x58, 0x64 and 0x5C. Data and direction are at 0x00/0x10 for port 0, 0x04/0x14 for port 1 and 0x30/0x34 for port 2. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 24 | Pad inputs: port 0 bits 7:0, port 1 bits 15:8, port 2 bits 23:16 |
| pin_out | output | 24 | Data register values to the pads |
| pin_oe | output | 24 | Direction register values (1 = drive) |
| irq_shared | output | 1 | Combined interrupt of ports 0 and 1 |
| irq_line | output | 8 | Per-pin interrupts of port 2 |

## Verification
The assertions assume that the bus is driven cleanly at each clock: a write holds its address and data together for exactly the strobe cycle. They also assume that reset is held for several clocks before it falls, so that every register carries its cleared value when the checks start. The stimulus changes bus and pad inputs only on the falling clock edge, pulses the write strobe for one clock, and holds reset for five clocks. Pad pulses are timed in whole clocks, so the debounce windows in the checks are exact.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT  = 3;
  localparam int PIN_W  = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    K_MODE, K_POL, K_ACK, K_EN, K_DEB, K_STAT, K_DATA, K_DIR
  } reg_kind_e;

  function automatic logic [ADDR_W-1:0] reg_off(input int port, input reg_kind_e k);
    logic [ADDR_W-1:0] r;
    r = '0;
    case (port)
      0: case (k)
           K_MODE: r = 8'h90; K_POL: r = 8'h94; K_ACK: r = 8'h98; K_EN: r = 8'h9C;
           K_DEB:  r = 8'hA8; K_STAT: r = 8'hA0; K_DATA: r = 8'h00; default: r = 8'h10;
         endcase
      1: case (k)
           K_MODE: r = 8'hAC; K_POL: r = 8'hB0; K_ACK: r = 8'hB4; K_EN: r = 8'hB8;
           K_DEB:  r = 8'hC4; K_STAT: r = 8'hBC; K_DATA: r = 8'h04; default: r = 8'h14;
         endcase
      default: case (k)
           K_MODE: r = 8'h4C; K_POL: r = 8'h50; K_ACK: r = 8'h54; K_EN: r = 8'h58;
           K_DEB:  r = 8'h64; K_STAT: r = 8'h5C; K_DATA: r = 8'h30; default: r = 8'h34;
         endcase
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_in_qual.sv
module gpio_in_qual #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_raw,
  input  logic [W-1:0] deb_en,
  output logic [W-1:0] sync_val,
  output logic [W-1:0] qual
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [W-1:0] chain [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= pin_raw;
      for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_val = chain[SYNC_STAGES-1];

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q   <= 1'b0;
        cnt <= '0;
      end else if (!deb_en[i]) begin
        q   <= sync_val[i];
        cnt <= '0;
      end else if (sync_val[i] == q) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
        q   <= sync_val[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign qual[i] = q;
  end
endmodule

// File: rtl/gpio_port_unit.sv
module gpio_port_unit
  import gpio_irq_pkg::*;
#(
  parameter int PORT_IDX    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  stat,
  output logic              rd_hit,
  output logic [PIN_W-1:0]  rd_val
);
  localparam logic [ADDR_W-1:0] A_MODE = reg_off(PORT_IDX, K_MODE);
  localparam logic [ADDR_W-1:0] A_POL  = reg_off(PORT_IDX, K_POL);
  localparam logic [ADDR_W-1:0] A_ACK  = reg_off(PORT_IDX, K_ACK);
  localparam logic [ADDR_W-1:0] A_EN   = reg_off(PORT_IDX, K_EN);
  localparam logic [ADDR_W-1:0] A_DEB  = reg_off(PORT_IDX, K_DEB);
  localparam logic [ADDR_W-1:0] A_STAT = reg_off(PORT_IDX, K_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = reg_off(PORT_IDX, K_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = reg_off(PORT_IDX, K_DIR);

  logic [PIN_W-1:0] mode_r, pol_r, en_r, deb_r, data_r, dir_r;
  logic [PIN_W-1:0] edge_lat, qual_d;
  logic [PIN_W-1:0] sync_val, qual;
  logic [PIN_W-1:0] rise, fall, edge_want, ack_clr, level_act;

  gpio_in_qual #(.W(PIN_W), .SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .pin_raw(pin_in), .deb_en(deb_r),
    .sync_val(sync_val), .qual(qual)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= '0; pol_r <= '0; en_r <= '0;
      deb_r  <= '0; data_r <= '0; dir_r <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: mode_r <= bus_wdata;
        A_POL:  pol_r  <= bus_wdata;
        A_EN:   en_r   <= bus_wdata;
        A_DEB:  deb_r  <= bus_wdata;
        A_DATA: data_r <= bus_wdata;
        A_DIR:  dir_r  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rise      = qual & ~qual_d;
    fall      = ~qual & qual_d;
    edge_want = (pol_r & rise) | (~pol_r & fall);
    ack_clr   = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
    level_act = ~(qual ^ pol_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d   <= '0;
      edge_lat <= '0;
    end else begin
      qual_d   <= qual;
      edge_lat <= (edge_lat & ~ack_clr) | (edge_want & en_r & mode_r);
    end
  end

  assign stat    = en_r & ((mode_r & edge_lat) | (~mode_r & level_act));
  assign pin_out = data_r;
  assign pin_oe  = dir_r;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    case (bus_addr)
      A_MODE: rd_val = mode_r;
      A_POL:  rd_val = pol_r;
      A_EN:   rd_val = en_r;
      A_DEB:  rd_val = deb_r;
      A_STAT: rd_val = stat;
      A_DATA: rd_val = (dir_r & data_r) | (~dir_r & sync_val);
      A_DIR:  rd_val = dir_r;
      A_ACK:  rd_val = '0;
      default: rd_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [PIN_W-1:0]        bus_wdata,
  output logic [PIN_W-1:0]        bus_rdata,
  input  logic [NPORT*PIN_W-1:0]  pin_in,
  output logic [NPORT*PIN_W-1:0]  pin_out,
  output logic [NPORT*PIN_W-1:0]  pin_oe,
  output logic                    irq_shared,
  output logic [PIN_W-1:0]        irq_line
);
  localparam int SHARED_A = 0;
  localparam int SHARED_B = 1;
  localparam int LINE_P   = 2;

  logic [PIN_W-1:0] port_stat [NPORT];
  logic [PIN_W-1:0] port_rd   [NPORT];
  logic [NPORT-1:0] port_hit;
  logic [PIN_W-1:0] rd_mux;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_port_unit #(.PORT_IDX(p), .SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_port (
      .clk(clk), .rst(rst),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .pin_in(pin_in[p*PIN_W +: PIN_W]),
      .pin_out(pin_out[p*PIN_W +: PIN_W]),
      .pin_oe(pin_oe[p*PIN_W +: PIN_W]),
      .stat(port_stat[p]),
      .rd_hit(port_hit[p]),
      .rd_val(port_rd[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++)
      if (port_hit[p]) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_shared <= 1'b0;
      irq_line   <= '0;
    end else begin
      bus_rdata  <= rd_mux;
      irq_shared <= |(port_stat[SHARED_A] | port_stat[SHARED_B]);
      irq_line   <= port_stat[LINE_P];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       irq_shared,
  input logic [7:0] irq_line,
  input logic [7:0] stat_a,
  input logic [7:0] stat_b,
  input logic [7:0] stat_f
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (irq_line == 8'h00 && !irq_shared));

  a_r7_shared_or: assert property (@(posedge clk) disable iff (rst)
    irq_shared == $past(|(stat_a | stat_b)));

  a_r8_line_follow: assert property (@(posedge clk) disable iff (rst)
    irq_line == $past(stat_f));

  a_r5_enable_off_a: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h9C && bus_wdata == 8'h00) |=> stat_a == 8'h00);

  a_r5_enable_off_f: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h58 && bus_wdata == 8'h00) |=> stat_f == 8'h00);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .irq_shared(irq_shared), .irq_line(irq_line),
  .stat_a(port_stat[0]), .stat_b(port_stat[1]), .stat_f(port_stat[2])
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;
  logic        irq_shared;
  logic [7:0]  irq_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_shared(irq_shared), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input int port, input logic [7:0] v);
    @(negedge clk);
    pin_in[port*8 +: 8] = v;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'hA0, v); chk("R1 status port0", v, 8'h00);
    rd(8'h5C, v); chk("R1 status port2", v, 8'h00);
    rd(8'h90, v); chk("R1 mode port0", v, 8'h00);
    chk("R1 irq_shared", irq_shared, 1'b0);
    chk("R1 irq_line", irq_line, 8'h00);
    chk("R1 pin_oe", pin_oe, 24'h0);
  endtask

  task automatic t_level();
    logic [7:0] v;
    wr(8'h90, 8'h00); wr(8'h94, 8'h04); wr(8'h9C, 8'h24);
    settle(6);
    rd(8'hA0, v); chk("R2 low-active pin5 only", v, 8'h20);
    chk("R7 shared from level", irq_shared, 1'b1);
    set_pins(0, 8'h04); settle(6);
    rd(8'hA0, v); chk("R2 both active", v, 8'h24);
    set_pins(0, 8'h24); settle(6);
    rd(8'hA0, v); chk("R2 high pin only", v, 8'h04);
    set_pins(0, 8'h20); settle(6);
    rd(8'hA0, v); chk("R2 none active", v, 8'h00);
    chk("R7 shared drops", irq_shared, 1'b0);
    set_pins(0, 8'h00); wr(8'h9C, 8'h00); settle(4);
    rd(8'hA0, v); chk("R5 disabled reads zero", v, 8'h00);
    chk("R5 shared quiet", irq_shared, 1'b0);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    wr(8'hAC, 8'hFF); wr(8'hB0, 8'h0F); wr(8'hB8, 8'hFF);
    set_pins(1, 8'hFF); settle(6);
    rd(8'hBC, v); chk("R3 rising latched", v, 8'h0F);
    chk("R7 shared from port1", irq_shared, 1'b1);
    set_pins(1, 8'h00); settle(6);
    rd(8'hBC, v); chk("R3 falling latched, rising held", v, 8'hFF);
    wr(8'hB4, 8'h00); settle(2);
    rd(8'hBC, v); chk("R4 zero ack no effect", v, 8'hFF);
    wr(8'hB4, 8'h0F); settle(2);
    rd(8'hBC, v); chk("R4 ack clears ones only", v, 8'hF0);
    wr(8'hB0, 8'h00); wr(8'hAC, 8'hFF); settle(2);
    rd(8'hBC, v); chk("R9 type write keeps latch", v, 8'hF0);
    wr(8'hB4, 8'hF0); settle(3);
    rd(8'hBC, v); chk("R4 all cleared", v, 8'h00);
    chk("R7 shared clears", irq_shared, 1'b0);
  endtask

  task automatic t_disabled_edge();
    logic [7:0] v;
    wr(8'hB0, 8'h01); wr(8'hB8, 8'h00);
    set_pins(1, 8'h01); settle(6);
    wr(8'hB8, 8'h01); settle(2);
    rd(8'hBC, v); chk("R5 edge while disabled dropped", v, 8'h00);
    wr(8'hB8, 8'h00); set_pins(1, 8'h00); settle(6);
  endtask

  task automatic t_lines();
    wr(8'h4C, 8'hFF); wr(8'h50, 8'hFF); wr(8'h58, 8'hFF);
    set_pins(2, 8'h08); settle(6);
    chk("R8 line for pin3", irq_line, 8'h08);
    chk("R7 port2 not shared", irq_shared, 1'b0);
    set_pins(2, 8'h00); wr(8'h54, 8'h08); settle(3);
    chk("R8 line cleared by ack", irq_line, 8'h00);
  endtask

  task automatic t_debounce();
    wr(8'h64, 8'h40);
    @(negedge clk); pin_in[22] = 1'b1;
    settle(3); pin_in[22] = 1'b0;
    settle(10);
    chk("R6 short pulse rejected", irq_line, 8'h00);
    @(negedge clk); pin_in[22] = 1'b1;
    settle(6); pin_in[22] = 1'b0;
    settle(10);
    chk("R6 long pulse accepted", irq_line, 8'h40);
    @(negedge clk); pin_in[23] = 1'b1;
    settle(1); pin_in[23] = 1'b0;
    settle(8);
    chk("R6 undebounced one-clock pulse", irq_line, 8'hC0);
    wr(8'h54, 8'hC0); settle(3);
    chk("R4 port2 acked", irq_line, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    wr(8'h00, 8'hA5); wr(8'h10, 8'h0F); wr(8'h34, 8'h3C);
    set_pins(0, 8'h30); settle(4);
    chk("R10 pin_out port0", pin_out[7:0], 8'hA5);
    chk("R10 pin_oe port0/port2", {pin_oe[23:16], pin_oe[7:0]}, 16'h3C0F);
    rd(8'h00, v); chk("R10 data readback mix", v, 8'h35);
    rd(8'h14, v); chk("R11 port1 direction untouched", v, 8'h00);
    set_pins(0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_level();
    t_edge();
    t_disabled_edge();
    t_lines();
    t_debounce();
    t_data();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule